// File: doc/BRIEF.md
# Memory Lock Protection Checker

This block decides whether an access made through the external programming interface may proceed. Two nonvolatile lock bits, modelled as a register that comes out of reset unprogrammed, select one of three protection modes. For each request the block looks at the access kind (read or write), the target memory space and the origin of the request. Requests that application software starts for itself are always allowed. Requests from the external programmer are filtered by the current mode. The block also drives a disable line for the on-chip debug port and reports the active mode.

The lock bits can only move toward more protection. A lock program command clears the bits selected by zeros in its value and leaves the others as they are. Only a chip erase command brings the bits back to the unprogrammed state. The grant decision is combinational on the current lock state, and every command takes effect on the next clock edge.

Top module: `lock_guard`

## Requirements
- R1: After reset both lock bits are unprogrammed, `mode` reads 1 and `debugDisable` is low.
- R2: Bit 0 of `lockProgValue` is lock bit A and bit 1 is lock bit B, with 1 meaning keep and 0 meaning program. `mode` is 1 when both bits are unprogrammed, 2 when only A is programmed, and 3 when both are programmed. B programmed while A is unprogrammed also gives 3. `mode` never reads 0.
- R3: In mode 1, external reads and writes to every valid space are granted. Space codes: 0 code, 1 data, 2 user signature, 3 factory signature, 4 configuration fuses.
- R4: In mode 2, external writes to every space are refused, and external reads of every valid space are granted.
- R5: In mode 3, external writes are refused and external reads of code and data are refused. External reads of the user signature, the factory signature and the fuses are granted.
- R6: `debugDisable` is high exactly when `mode` is 3.
- R7: A lock program command can only program bits, and it takes effect on the next clock edge. A bit given as 1 keeps its present state, so a programmed bit is never restored.
- R8: `grant` is high in the same cycle as `eraseCmd`. On the next edge both lock bits return to unprogrammed (mode 1). When both commands come in one cycle, chip erase takes precedence over a lock program command.
- R9: A request with `reqSoftware` high to a valid space is granted in every mode, for reads and writes alike.
- R10: Space codes 5 to 7 are never granted. `grant` is low when neither `reqValid` nor `eraseCmd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | An access request is present |
| reqWrite | input | 1 | 1 = write/program, 0 = read |
| reqSpace | input | 3 | Target space code |
| reqSoftware | input | 1 | Request started by application software |
| eraseCmd | input | 1 | Chip erase command |
| lockProgCmd | input | 1 | Lock bit program command |
| lockProgValue | input | 2 | Per-bit value: 0 programs the bit, 1 keeps it |
| grant | output | 1 | Access or erase allowed this cycle |
| debugDisable | output | 1 | Debug port shut off |
| mode | output | 2 | Active protection mode (1, 2 or 3) |

## Verification
`grant` is a same-cycle result, so the bench drives a request on the falling edge and samples `grant` one nanosecond later, before the next rising edge. `mode` and `debugDisable` change one rising edge after a lock program or erase command. The bench holds each command across exactly one rising edge, drops it at the following falling edge and only then samples the mode. A bench model of the two lock bits, updated at that same edge, supplies every expected value.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;

  localparam int LOCK_BITS = 2;
  localparam int SPACE_W   = 3;
  localparam int MODE_W    = 2;

  typedef enum logic [SPACE_W-1:0] {
    SP_CODE  = 3'd0,
    SP_DATA  = 3'd1,
    SP_USIG  = 3'd2,
    SP_FSIG  = 3'd3,
    SP_FUSE  = 3'd4
  } space_e;

  typedef enum logic [MODE_W-1:0] {
    MODE_OPEN   = 2'd1,
    MODE_NOPROG = 2'd2,
    MODE_SEALED = 2'd3
  } mode_e;

  typedef struct packed {
    logic                 eraseStb;
    logic                 progStb;
    logic [LOCK_BITS-1:0] keepMask;
  } lock_stb_t;

endpackage

// File: rtl/lock_guard_ctrl.sv
module lock_guard_ctrl
  import lock_guard_pkg::*;
(
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [SPACE_W-1:0]   reqSpace,
  input  logic                 reqSoftware,
  input  logic                 eraseCmd,
  input  logic                 lockProgCmd,
  input  logic [LOCK_BITS-1:0] lockProgValue,
  input  mode_e                modeNow,
  output lock_stb_t            stb,
  output logic                 grant
);

  logic spaceValid;
  logic spaceReadable3;
  logic extAllowed;

  // erase wins over lock programming in the same cycle
  always_comb begin
    stb.eraseStb = eraseCmd;
    stb.progStb  = lockProgCmd & ~eraseCmd;
    stb.keepMask = lockProgValue;
  end

  always_comb begin
    spaceValid     = (reqSpace <= SP_FUSE);
    spaceReadable3 = (reqSpace == SP_USIG) || (reqSpace == SP_FSIG) ||
                     (reqSpace == SP_FUSE);
    unique case (modeNow)
      MODE_OPEN:   extAllowed = 1'b1;
      MODE_NOPROG: extAllowed = ~reqWrite;
      default:     extAllowed = ~reqWrite & spaceReadable3;
    endcase
  end

  assign grant = eraseCmd |
                 (reqValid & spaceValid & (reqSoftware | extAllowed));

endmodule

// File: rtl/lock_guard_store.sv
module lock_guard_store
  import lock_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  lock_stb_t stb,
  output mode_e     modeNow,
  output logic      debugDisable
);

  logic [LOCK_BITS-1:0] lockBits;   // 1 = unprogrammed

  for (genvar i = 0; i < LOCK_BITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             lockBits[i] <= 1'b1;
      else if (stb.eraseStb) lockBits[i] <= 1'b1;
      else if (stb.progStb)  lockBits[i] <= lockBits[i] & stb.keepMask[i];
    end
  end

  always_comb begin
    unique case (lockBits)
      2'b11:   modeNow = MODE_OPEN;
      2'b10:   modeNow = MODE_NOPROG;
      default: modeNow = MODE_SEALED;
    endcase
  end

  assign debugDisable = (lockBits != 2'b11) && (lockBits != 2'b10);

  // R7: without erase no bit goes from programmed back to unprogrammed
  a_r7_only_program: assert property (@(posedge clk) disable iff (!rstN)
    !stb.eraseStb |=> ((lockBits & ~$past(lockBits)) == '0));

  // R8: erase restores the unprogrammed state on the next edge
  a_r8_erase_restores: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseStb |=> (lockBits == '1));

endmodule

// File: rtl/lock_guard.sv
module lock_guard
  import lock_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [SPACE_W-1:0]   reqSpace,
  input  logic                 reqSoftware,
  input  logic                 eraseCmd,
  input  logic                 lockProgCmd,
  input  logic [LOCK_BITS-1:0] lockProgValue,
  output logic                 grant,
  output logic                 debugDisable,
  output logic [MODE_W-1:0]    mode
);

  lock_stb_t stb;
  mode_e     modeNow;

  lock_guard_ctrl u_ctrl (
    .reqValid      (reqValid),
    .reqWrite      (reqWrite),
    .reqSpace      (reqSpace),
    .reqSoftware   (reqSoftware),
    .eraseCmd      (eraseCmd),
    .lockProgCmd   (lockProgCmd),
    .lockProgValue (lockProgValue),
    .modeNow       (modeNow),
    .stb           (stb),
    .grant         (grant)
  );

  lock_guard_store u_store (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .modeNow      (modeNow),
    .debugDisable (debugDisable)
  );

  assign mode = modeNow;

  // R2: mode never reads zero
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    mode != 2'd0);

  // R6: debug port shut off exactly in mode 3
  a_r6_debug_tracks_mode: assert property (@(posedge clk) disable iff (!rstN)
    debugDisable == (mode == 2'd3));

  // R4 / R5: no external write is granted once locked
  a_r4_locked_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqSoftware && !eraseCmd && mode != 2'd1) |-> !grant);

  // R9: software requests to valid spaces always pass
  a_r9_software_passes: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSoftware && reqSpace <= 3'd4) |-> grant);

  // R10: reserved space codes never pass
  a_r10_reserved_denied: assert property (@(posedge clk) disable iff (!rstN)
    (reqSpace > 3'd4 && !eraseCmd) |-> !grant);

endmodule

// File: tb/tb_lock_guard.sv
`timescale 1ns/1ps
module tb_lock_guard;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqWrite = 1'b0;
  logic [2:0] reqSpace = 3'd0;
  logic       reqSoftware = 1'b0;
  logic       eraseCmd = 1'b0;
  logic       lockProgCmd = 1'b0;
  logic [1:0] lockProgValue = 2'b11;
  logic       grant;
  logic       debugDisable;
  logic [1:0] mode;

  int checks = 0;
  int failures = 0;
  logic [1:0] modelBits = 2'b11;   // bench model, 1 = unprogrammed

  always #2.5 clk = ~clk;

  lock_guard dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSpace(reqSpace), .reqSoftware(reqSoftware), .eraseCmd(eraseCmd),
    .lockProgCmd(lockProgCmd), .lockProgValue(lockProgValue),
    .grant(grant), .debugDisable(debugDisable), .mode(mode)
  );

  function automatic int expMode(logic [1:0] b);
    if (b == 2'b11) return 1;
    if (b == 2'b10) return 2;
    return 3;
  endfunction

  function automatic bit expGrant(int m, bit v, bit w, int sp, bit sw, bit er);
    if (er) return 1'b1;
    if (!v) return 1'b0;
    if (sp > 4) return 1'b0;
    if (sw) return 1'b1;
    if (m == 1) return 1'b1;
    if (w) return 1'b0;
    if (m == 2) return 1'b1;
    return (sp >= 2);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkMode(string req);
    @(negedge clk); #1;
    check(req, int'(mode), expMode(modelBits), "mode");
    check("R6", int'(debugDisable), int'(expMode(modelBits) == 3), "debugDisable");
  endtask

  task automatic progLock(logic [1:0] val);
    @(negedge clk);
    lockProgCmd = 1'b1; lockProgValue = val;
    @(posedge clk);
    modelBits = modelBits & val;
    @(negedge clk);
    lockProgCmd = 1'b0; lockProgValue = 2'b11;
  endtask

  // every write/space/origin combination in the current mode
  task automatic sweepAccess();
    int m = expMode(modelBits);
    for (int sw = 0; sw < 2; sw++)
      for (int w = 0; w < 2; w++)
        for (int sp = 0; sp < 8; sp++) begin
          string req;
          @(negedge clk);
          reqValid = 1'b1; reqWrite = w[0]; reqSpace = sp[2:0]; reqSoftware = sw[0];
          #1;
          if (sp > 4)       req = "R10";
          else if (sw != 0) req = "R9";
          else if (m == 1)  req = "R3";
          else if (m == 2)  req = "R4";
          else              req = "R5";
          check(req, int'(grant), int'(expGrant(m, 1'b1, w[0], sp, sw[0], 1'b0)), "grant");
        end
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqSpace = 3'd0; reqSoftware = 1'b0;
    #1;
    check("R10", int'(grant), 0, "grant idle");
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    modelBits = 2'b11;
    #1;
    check("R1", int'(mode), 1, "mode after reset");
    check("R1", int'(debugDisable), 0, "debugDisable after reset");
  endtask

  task automatic t_mode1();  sweepAccess(); endtask

  task automatic t_mode2();
    progLock(2'b10);           // program A only
    checkMode("R2");
    sweepAccess();
  endtask

  task automatic t_monotonic();
    progLock(2'b11);           // keep everything: no change
    checkMode("R7");
    check("R7", int'(mode), 2, "mode after keep-all");
  endtask

  task automatic t_mode3();
    progLock(2'b01);           // program B as well
    checkMode("R2");
    check("R5", int'(mode), 3, "mode both programmed");
    sweepAccess();
    progLock(2'b11);
    checkMode("R7");
  endtask

  task automatic t_erase();
    @(negedge clk);
    eraseCmd = 1'b1; reqValid = 1'b0;
    #1;
    check("R8", int'(grant), 1, "grant on erase");
    check("R8", int'(mode), 3, "mode before erase edge");
    @(posedge clk);
    modelBits = 2'b11;
    @(negedge clk); eraseCmd = 1'b0;
    #1;
    check("R8", int'(mode), 1, "mode after erase");
    check("R6", int'(debugDisable), 0, "debugDisable after erase");
  endtask

  task automatic t_odd_combo();
    progLock(2'b01);           // B programmed, A kept
    checkMode("R2");
    check("R2", int'(mode), 3, "odd combination");
    sweepAccess();
  endtask

  task automatic t_erase_precedence();
    @(negedge clk);
    eraseCmd = 1'b1; lockProgCmd = 1'b1; lockProgValue = 2'b00;
    @(posedge clk);
    modelBits = 2'b11;
    @(negedge clk);
    eraseCmd = 1'b0; lockProgCmd = 1'b0; lockProgValue = 2'b11;
    #1;
    check("R8", int'(mode), 1, "erase beats program");
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_mode1();
    t_mode2();
    t_monotonic();
    t_mode3();
    t_erase();
    t_odd_combo();
    t_erase();
    t_erase_precedence();
    sweepAccess();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule